// File: doc/BRIEF.md
# Periodic Trace Synchronization Timer

This block decides when a trace output stream should carry a synchronization packet. It counts the bytes that leave the trace port, one per cycle in which the byte strobe is high. When a programmed number of bytes has gone out, it raises a request for exactly one clock. The packet builder that consumes the request is not part of this block.

The period is set through a small register that holds a power-of-two exponent. A value of zero switches periodic synchronization off. A nonzero value n gives a period of 2^n bytes. A new value never upsets a count that is already running. It is taken only when the running count next reaches zero, so the period in progress always finishes at its old length. Reading the register returns the programmed exponent, not the live count.

Top module: `tsc_sync_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and `sync_req` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata`, and `cfg_rdata` shows that value from the cycle after the write. The read value is always the programmed exponent and never the running count.
- R3: While the programmed exponent is 0 and the timer is idle, no request is raised, whatever the strobe does.
- R4: With exponent n (1 to 31) loaded, a request is raised after every 2^n-th strobe counted since the load. For example, n=7 gives one request per 128 bytes.
- R5: When a nonzero exponent is written while the timer is idle, the count loads on the clock edge after the write. Strobes in the write cycle and in the load cycle are not counted.
- R6: Rewriting the exponent while a period is running does not change that period. The new exponent sets the length of the period that starts at the next request.
- R7: Writing 0 while a period is running lets that period end with its request. The timer then goes idle and raises no further requests.
- R8: `sync_req` is high for exactly one cycle: the cycle that follows the clock edge at which the final strobe of the period is captured.
- R9: Cycles without a strobe do not advance the count, so idle gaps between bytes do not shorten or lengthen the period measured in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | One trace byte was emitted this cycle |
| cfg_we | input | 1 | Write strobe for the exponent register |
| cfg_wdata | input | 5 | Exponent to program; 0 disables |
| cfg_rdata | output | 5 | Programmed exponent (read-back) |
| sync_req | output | 1 | One-cycle synchronization request |

## Verification
Each result has a fixed latency:
- A write shows on `cfg_rdata` one cycle after its edge.
- A write from idle loads the count on the next edge, so counting starts with the strobe after that.
- A request appears in the cycle right after the edge that captures the last strobe of the period.

The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Each strobe is therefore compared with the request it must or must not produce in that same step. The expected request is computed arithmetically: it is due when the strobe index since the load is a multiple of 2^n. For the mid-period rewrites, the expected schedule switches to the new period only after the request that closes the current one.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [0:0] {
    TSC_IDLE = 1'b0,
    TSC_RUN  = 1'b1
  } tsc_state_e;
endpackage

// File: rtl/tsc_cfg_reg.sv
module tsc_cfg_reg #(
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [EXP_W-1:0] wdata_i,
  output logic [EXP_W-1:0] exp_o
);
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             exp_en;

  always_comb begin
    exp_en = we_i;
    exp_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= '0;
    else if (exp_en) exp_q <= exp_d;
  end

  assign exp_o = exp_q;

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (exp_o == $past(wdata_i)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(exp_o));
endmodule

// File: rtl/tsc_reload_gen.sv
module tsc_reload_gen #(
  parameter int EXP_W = 5,
  parameter int CNT_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             enable_o
);
  // reload = 2^exp - 1: every bit below the exponent is set
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign reload_o[i] = (int'(exp_i) > i);
  end

  assign enable_o = |exp_i;
endmodule

// File: rtl/tsc_down_counter.sv
module tsc_down_counter
  import tsc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             cfg_on_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             req_o
);
  tsc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             req_q, req_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    req_d   = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      TSC_IDLE: begin
        if (cfg_on_i) begin
          cnt_en  = 1'b1;
          cnt_d   = reload_i;
          state_d = TSC_RUN;
        end
      end
      TSC_RUN: begin
        if (stb_i) begin
          cnt_en = 1'b1;
          if (at_zero) begin
            req_d = 1'b1;
            if (cfg_on_i) begin
              cnt_d = reload_i;
            end else begin
              cnt_d   = '0;
              state_d = TSC_IDLE;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: state_d = TSC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TSC_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign req_o = req_q;

  // R8
  one_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TSC_IDLE) |=> !req_q);

  // R9
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TSC_RUN) && !stb_i) |=> $stable(cnt_q));

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TSC_RUN) && stb_i && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  deferred_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TSC_RUN) && stb_i && at_zero && cfg_on_i) |=> (cnt_q == $past(reload_i)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TSC_IDLE) |-> at_zero);
endmodule

// File: rtl/tsc_sync_timer.sv
module tsc_sync_timer #(
  parameter int EXP_W = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic             cfg_we,
  input  logic [EXP_W-1:0] cfg_wdata,
  output logic [EXP_W-1:0] cfg_rdata,
  output logic             sync_req
);
  logic [EXP_W-1:0] exp_val;
  logic [CNT_W-1:0] reload_val;
  logic             cfg_on;

  tsc_cfg_reg #(.EXP_W(EXP_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .exp_o   (exp_val)
  );

  tsc_reload_gen #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_reload (
    .exp_i    (exp_val),
    .reload_o (reload_val),
    .enable_o (cfg_on)
  );

  tsc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (byte_stb),
    .cfg_on_i (cfg_on),
    .reload_i (reload_val),
    .req_o    (sync_req)
  );

  assign cfg_rdata = exp_val;

  // R8
  req_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> $past(byte_stb));
endmodule

// File: tb/tb_tsc_sync_timer.sv
module tb_tsc_sync_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_stb;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic [4:0] cfg_rdata;
  logic       sync_req;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  tsc_sync_timer dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sync_req(sync_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive on falling edge, sample 1 ns after the following rising edge
  task automatic cyc(input logic s, input logic w, input logic [4:0] d);
    @(negedge clk);
    byte_stb  = s;
    cfg_we    = w;
    cfg_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; byte_stb = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_stb = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    do_reset();
    #1;
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 req", sync_req, 0);

    // R3: exponent 0, strobes produce nothing
    cyc(1'b0, 1'b1, 5'd0);
    chk("R2 rdata", cfg_rdata, 0);
    for (int k = 0; k < 40; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R3 disabled", sync_req, 0);
    end

    // R4 sweep over exponents 1..12, two periods each
    for (int n = 1; n <= 12; n++) begin
      do_reset();
      cyc(1'b0, 1'b1, 5'(n));
      chk("R2 rdata", cfg_rdata, n);
      cyc(1'b0, 1'b0, 5'd0);
      for (int k = 1; k <= (2 << n); k++) begin
        cyc(1'b1, 1'b0, 5'd0);
        chk("R4 period", sync_req, ((k % (1 << n)) == 0) ? 1 : 0);
      end
      chk("R2 rdata not count", cfg_rdata, n);
    end

    // R5: strobes in write cycle and load cycle are ignored
    do_reset();
    cyc(1'b1, 1'b1, 5'd3);
    chk("R5 write cycle", sync_req, 0);
    cyc(1'b1, 1'b0, 5'd0);
    chk("R5 load cycle", sync_req, 0);
    for (int k = 1; k <= 16; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R5 first period", sync_req, ((k % 8) == 0) ? 1 : 0);
    end

    // R9 + R8: gaps between strobes; request lasts one cycle
    do_reset();
    cyc(1'b0, 1'b1, 5'd3);
    cyc(1'b0, 1'b0, 5'd0);
    for (int k = 1; k <= 16; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R9 gapped", sync_req, ((k % 8) == 0) ? 1 : 0);
      for (int g = 0; g < (k % 3); g++) begin
        cyc(1'b0, 1'b0, 5'd0);
        chk("R8 single cycle", sync_req, 0);
      end
    end

    // R6: rewrite mid-count, old period finishes, then new one applies
    do_reset();
    cyc(1'b0, 1'b1, 5'd4);
    cyc(1'b0, 1'b0, 5'd0);
    for (int k = 1; k <= 5; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R6 before rewrite", sync_req, 0);
    end
    cyc(1'b1, 1'b1, 5'd2);       // strobe 6 together with the rewrite
    chk("R6 rewrite cycle", sync_req, 0);
    chk("R2 rdata rewrite", cfg_rdata, 2);
    for (int k = 7; k <= 16; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R6 old period", sync_req, (k == 16) ? 1 : 0);
    end
    for (int k = 1; k <= 12; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R6 new period", sync_req, ((k % 4) == 0) ? 1 : 0);
    end

    // R7: write 0 mid-count, current period ends, then silence
    do_reset();
    cyc(1'b0, 1'b1, 5'd2);
    cyc(1'b0, 1'b0, 5'd0);
    cyc(1'b1, 1'b0, 5'd0);
    chk("R7 strobe1", sync_req, 0);
    cyc(1'b1, 1'b1, 5'd0);
    chk("R7 strobe2", sync_req, 0);
    chk("R2 rdata zero", cfg_rdata, 0);
    cyc(1'b1, 1'b0, 5'd0);
    chk("R7 strobe3", sync_req, 0);
    cyc(1'b1, 1'b0, 5'd0);
    chk("R7 last request", sync_req, 1);
    for (int k = 0; k < 30; k++) begin
      cyc(1'b1, 1'b0, 5'd0);
      chk("R7 disabled after", sync_req, 0);
    end

    finish_run();
  end
endmodule